// File: doc/BRIEF.md
# Immediate Command Register Engine

This block gives a host a small register window for sending one control command at a time to a device on an audio control bus and collecting the 64-bit answer. The host places the target device number, command code and high register-address byte in the upper command word. It then writes the low address byte and the write data into the lower command word. The lower-word write starts the command. While the command is outstanding a busy flag is raised. When the command ends, a response is latched and a response-valid flag is set. The host reads the two response words and clears the valid flag by writing a one to it.

A behavioural responder stands in for the far end of the bus. Its answer mode (ACK, NACK or silence), delay, read data and twelve-device presence map come in on plain input ports. If no answer arrives within `TIMEOUT_CYC` cycles, the block completes the command with both ACK and NACK clear, which means the command was ignored. Writing a command while the previous response is still valid is legal, but it leaves a sticky stale-state flag for the host to clear. Command writes that arrive while busy are discarded and leave a sticky overrun flag.

Top module: `imm_cmd_engine`

## Requirements
- R1: After reset every readable register (offsets 0 to 4) reads zero.
- R2: Offset 0 holds the upper command word (device number in bits 23:20, command code in bits 18:16, where code 2 is read and code 3 is write, high address byte in bits 15:8). Offset 1 holds the lower command word (low address byte in bits 15:8, write data in bits 7:0). Both read back as written while the block is idle.
- R3: A write to offset 1 while idle starts a command, and status bit 0 (busy) reads one from the next cycle. With responder delay d below the timeout, busy stays set for exactly d+1 cycles.
- R4: An ACK answer sets response bit 0 (offset 4). For a read command it places the responder data in offset 4 bits 15:8; for any other command those bits are zero. The response words change only when a command completes.
- R5: A NACK answer sets response bit 1 and clears bit 0, and ACK and NACK are never both set.
- R6: With a silent responder, or with a delay of at least `TIMEOUT_CYC`, busy lasts exactly `TIMEOUT_CYC` cycles and the response has bits 1:0 both zero.
- R7: A command whose two words are both zero is a ping. On ACK, the presence map for devices 0 to 3 appears in offset 4 bits 27:24 and the map for devices 4 to 11 appears in offset 3 bits 7:0.
- R8: Completion clears busy and sets status bit 1 (response valid). Busy and response valid are never set together.
- R9: Writing offset 2 clears each of status bits 1, 2 and 3 whose write-data bit is one. Zero bits leave the status unchanged.
- R10: A write to offset 0 or 1 while busy is dropped without changing the stored words, and it sets status bit 2 (overrun).
- R11: Starting a command while response valid is set sets status bit 3 (stale) and clears response valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |
| rsp_mode | input | 2 | Responder mode: 0 ACK, 1 NACK, 2 or 3 silent |
| rsp_delay | input | 8 | Responder answer delay in cycles |
| rsp_rdata | input | 8 | Data the responder returns on reads |
| dev_map | input | 12 | Device presence map returned on pings |

## Verification
A wrong busy or response-valid state shows up in the status word on the very cycle it goes wrong. The bench model predicts the status on every clock, so an early or late completion, a missed launch or a dropped flag is reported within one cycle. Mistakes in field packing are confined to the response words. They surface at the read of offsets 3 and 4 after each completion, under ACK, NACK, timeout and ping answers. A counter that stops at the wrong value surfaces as a busy run of the wrong length, which is measured cycle by cycle against d+1 or the timeout.

// File: rtl/imm_cmd_pkg.sv
package imm_cmd_pkg;
  localparam int REG_AW = 3;
  localparam int WORD_W = 32;
  localparam int MAP_W  = 12;
  localparam int BYTE_W = 8;

  localparam logic [REG_AW-1:0] OFF_CMD_HI  = 3'd0;
  localparam logic [REG_AW-1:0] OFF_CMD_LO  = 3'd1;
  localparam logic [REG_AW-1:0] OFF_STATUS  = 3'd2;
  localparam logic [REG_AW-1:0] OFF_RESP_HI = 3'd3;
  localparam logic [REG_AW-1:0] OFF_RESP_LO = 3'd4;

  localparam logic [2:0] CODE_READ  = 3'd2;
  localparam logic [2:0] CODE_WRITE = 3'd3;

  localparam logic [1:0] MODE_ACK  = 2'd0;
  localparam logic [1:0] MODE_NACK = 2'd1;

  typedef struct packed {
    logic              ack;
    logic              nack;
    logic [BYTE_W-1:0] rdata;
    logic [MAP_W-1:0]  map;
  } answer_t;

  function automatic logic [2:0] cmd_code(input logic [WORD_W-1:0] hi);
    return hi[18:16];
  endfunction

  function automatic logic is_ping(input logic [WORD_W-1:0] hi,
                                   input logic [WORD_W-1:0] lo);
    return (hi == '0) && (lo == '0);
  endfunction

  function automatic logic [2*WORD_W-1:0] pack_resp(input answer_t a);
    logic [2*WORD_W-1:0] r;
    r         = '0;
    r[0]      = a.ack;
    r[1]      = a.nack;
    r[15:8]   = a.rdata;
    r[27:24]  = a.map[3:0];
    r[39:32]  = a.map[11:4];
    return r;
  endfunction
endpackage

// File: rtl/imm_cmd_timer.sv
module imm_cmd_timer #(
  parameter int TIMEOUT_CYC = 40,
  parameter int CNT_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= '0;
    else if (busy && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expire = busy && (cnt == LAST);
endmodule

// File: rtl/imm_cmd_responder.sv
module imm_cmd_responder
  import imm_cmd_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int DLY_W = 8
) (
  input  logic              busy,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [1:0]        mode,
  input  logic [DLY_W-1:0]  delay,
  input  logic [WORD_W-1:0] cmd_hi,
  input  logic [WORD_W-1:0] cmd_lo,
  input  logic [BYTE_W-1:0] rdata,
  input  logic [MAP_W-1:0]  dev_map,
  output logic              fire,
  output answer_t           ans
);
  logic ping;
  logic ack;

  assign ping = is_ping(cmd_hi, cmd_lo);
  assign ack  = (mode == MODE_ACK);
  assign fire = busy && !mode[1] && (32'(cnt) == 32'(delay));

  always_comb begin
    ans.ack   = ack;
    ans.nack  = (mode == MODE_NACK);
    ans.rdata = (ack && !ping && cmd_code(cmd_hi) == CODE_READ) ? rdata : '0;
    ans.map   = (ack && ping) ? dev_map : '0;
  end
endmodule

// File: rtl/imm_cmd_engine.sv
module imm_cmd_engine
  import imm_cmd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 40,
  parameter int DLY_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic [1:0]        rsp_mode,
  input  logic [DLY_W-1:0]  rsp_delay,
  input  logic [BYTE_W-1:0] rsp_rdata,
  input  logic [MAP_W-1:0]  dev_map
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic [WORD_W-1:0]   hi_q, lo_q;
  logic [2*WORD_W-1:0] resp_q;
  logic                busy_q, valid_q, overrun_q, stale_q;

  logic wr_hi, wr_lo, wr_st;
  logic launch, drop, done;
  logic fire, expire;
  logic [CNT_W-1:0] cnt;
  answer_t ans, fin;

  assign wr_hi  = wr_en && (wr_addr == OFF_CMD_HI);
  assign wr_lo  = wr_en && (wr_addr == OFF_CMD_LO);
  assign wr_st  = wr_en && (wr_addr == OFF_STATUS);
  assign launch = wr_lo && !busy_q;
  assign drop   = (wr_hi || wr_lo) && busy_q;
  assign done   = busy_q && (fire || expire);

  imm_cmd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(launch), .busy(busy_q),
    .cnt(cnt), .expire(expire)
  );

  imm_cmd_responder #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_resp (
    .busy(busy_q), .cnt(cnt), .mode(rsp_mode), .delay(rsp_delay),
    .cmd_hi(hi_q), .cmd_lo(lo_q), .rdata(rsp_rdata), .dev_map(dev_map),
    .fire(fire), .ans(ans)
  );

  assign fin = fire ? ans : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q      <= '0;
      lo_q      <= '0;
      resp_q    <= '0;
      busy_q    <= 1'b0;
      valid_q   <= 1'b0;
      overrun_q <= 1'b0;
      stale_q   <= 1'b0;
    end else begin
      if (wr_hi && !busy_q) hi_q <= wr_data;
      if (launch)           lo_q <= wr_data;

      if (launch)    busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;

      if (done)                        valid_q <= 1'b1;
      else if (launch)                 valid_q <= 1'b0;
      else if (wr_st && wr_data[1])    valid_q <= 1'b0;

      if (drop)                        overrun_q <= 1'b1;
      else if (wr_st && wr_data[2])    overrun_q <= 1'b0;

      if (launch && valid_q)           stale_q <= 1'b1;
      else if (wr_st && wr_data[3])    stale_q <= 1'b0;

      if (done) resp_q <= pack_resp(fin);
    end
  end

  always_comb begin
    unique case (rd_addr)
      OFF_CMD_HI:  rd_data = hi_q;
      OFF_CMD_LO:  rd_data = lo_q;
      OFF_STATUS:  rd_data = {28'd0, stale_q, overrun_q, valid_q, busy_q};
      OFF_RESP_HI: rd_data = resp_q[2*WORD_W-1:WORD_W];
      OFF_RESP_LO: rd_data = resp_q[WORD_W-1:0];
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/imm_cmd_engine_chk.sv
module imm_cmd_engine_chk #(
  parameter int TIMEOUT_CYC = 40
) (
  input logic        clk,
  input logic        rst_n,
  input logic        launch,
  input logic        done,
  input logic        drop,
  input logic        busy,
  input logic        valid,
  input logic        overrun,
  input logic [63:0] resp
);
  int run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) run_cnt <= 0;
    else                 run_cnt <= run_cnt + 1;
  end

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n) launch |=> busy); // R3
  AST_RESP_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !done |=> $stable(resp)); // R4
  AST_ACK_NACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n) valid |-> !(resp[0] && resp[1])); // R5
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> run_cnt < TIMEOUT_CYC); // R6
  AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n) done |=> (valid && !busy)); // R8
  AST_BUSY_VALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy && valid)); // R8
  AST_DROP_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n) drop |=> overrun); // R10
endmodule

bind imm_cmd_engine imm_cmd_engine_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .done(done), .drop(drop),
  .busy(busy_q), .valid(valid_q), .overrun(overrun_q), .resp(resp_q)
);

// File: tb/imm_cmd_engine_tb.sv
`timescale 1ns/1ps
module imm_cmd_engine_tb;
  localparam int TMO = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd2;
  logic [31:0] rd_data;
  logic [1:0]  rsp_mode = 2'd0;
  logic [7:0]  rsp_delay = 8'd0;
  logic [7:0]  rsp_rdata = 8'd0;
  logic [11:0] dev_map = 12'd0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  imm_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rsp_mode(rsp_mode), .rsp_delay(rsp_delay),
    .rsp_rdata(rsp_rdata), .dev_map(dev_map)
  );

  // behavioural reference model
  bit        m_busy, m_valid, m_ovr, m_stale;
  int        m_cnt;
  bit [31:0] m_hi, m_lo, m_rhi, m_rlo;

  always @(posedge clk) begin
    bit old_busy, ans, tmo, ack, nack, ping;
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_ovr = 0; m_stale = 0; m_cnt = 0;
      m_hi = 0; m_lo = 0; m_rhi = 0; m_rlo = 0;
    end else begin
      old_busy = m_busy;
      ans = m_busy && (rsp_mode < 2) && (m_cnt == int'(rsp_delay));
      tmo = m_busy && !ans && (m_cnt == TMO - 1);
      if (wr_en && wr_addr == 3'd2) begin
        if (wr_data[1]) m_valid = 0;
        if (wr_data[2]) m_ovr = 0;
        if (wr_data[3]) m_stale = 0;
      end
      if (m_busy) begin
        if (ans || tmo) begin
          ack  = ans && rsp_mode == 2'd0;
          nack = ans && rsp_mode == 2'd1;
          ping = (m_hi == 0) && (m_lo == 0);
          m_rlo = {30'd0, nack, ack};
          m_rhi = 0;
          if (ack && !ping && m_hi[18:16] == 3'd2) m_rlo[15:8] = rsp_rdata;
          if (ack && ping) begin
            m_rlo[27:24] = dev_map[3:0];
            m_rhi[7:0]   = dev_map[11:4];
          end
          m_busy = 0; m_valid = 1;
        end else m_cnt++;
      end else if (wr_en && wr_addr == 3'd1) begin
        m_lo = wr_data;
        if (m_valid) m_stale = 1;
        m_valid = 0; m_busy = 1; m_cnt = 0;
      end
      if (wr_en && (wr_addr == 3'd0 || wr_addr == 3'd1) && old_busy) m_ovr = 1;
      if (wr_en && wr_addr == 3'd0 && !old_busy) m_hi = wr_data;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // per-cycle status comparison against the model (R3, R8)
  always @(negedge clk) begin
    #1;
    if (rst_n && rd_addr == 3'd2 && !finished)
      chk("R8 status per cycle", rd_data, {28'd0, m_stale, m_ovr, m_valid, m_busy});
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    #2; rd_addr = a;
    #1; v = rd_data;
    rd_addr = 3'd2;
  endtask

  // issue a command and return the number of cycles busy reads one
  task automatic issue(input logic [31:0] hi, input logic [31:0] lo, output int nbusy);
    logic [31:0] s;
    wr(3'd0, hi);
    wr(3'd1, lo);
    nbusy = 0;
    for (int k = 0; k < 400; k++) begin
      rd(3'd2, s);
      if (!s[0]) break;
      nbusy++;
      @(negedge clk);
    end
  endtask

  task automatic chk_resp(input string req, input logic [31:0] ehi, input logic [31:0] elo);
    logic [31:0] v;
    @(negedge clk);
    rd(3'd3, v); chk(req, v, ehi); chk({req, " model"}, v, m_rhi);
    rd(3'd4, v); chk(req, v, elo); chk({req, " model"}, v, m_rlo);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int nb;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk("R1 reset register", v, 32'd0);
    end

    // R2, R3, R4: write command ACKed after delay 3
    rsp_mode = 2'd0; rsp_delay = 8'd3; rsp_rdata = 8'h77;
    issue(32'h0053_1200, 32'h0000_34A5, nb);
    chk("R3 busy length d+1", nb, 32'd4);
    rd(3'd0, v); chk("R2 upper readback", v, 32'h0053_1200);
    rd(3'd1, v); chk("R2 lower readback", v, 32'h0000_34A5);
    chk_resp("R4 write ack", 32'd0, 32'h0000_0001);
    rd(3'd2, v); chk("R8 valid after completion", v, 32'h2);

    // R9 W1C semantics
    wr(3'd2, 32'h0000_0000);
    rd(3'd2, v); chk("R9 zero write keeps valid", v, 32'h2);
    wr(3'd2, 32'h0000_0002);
    rd(3'd2, v); chk("R9 one clears valid", v, 32'h0);

    // R4 read ACK, delay 0
    rsp_delay = 8'd0; rsp_rdata = 8'h5C;
    issue(32'h0032_0100, 32'h0000_2000, nb);
    chk("R3 busy length delay 0", nb, 32'd1);
    chk_resp("R4 read data", 32'd0, 32'h0000_5C01);
    wr(3'd2, 32'hE);

    // R5 NACK
    rsp_mode = 2'd1; rsp_delay = 8'd5;
    issue(32'h0012_0000, 32'h0000_0100, nb);
    chk("R3 busy length nack", nb, 32'd6);
    chk_resp("R5 nack", 32'd0, 32'h0000_0002);
    wr(3'd2, 32'hE);

    // R6 silent responder
    rsp_mode = 2'd2;
    issue(32'h0073_0000, 32'h0000_0011, nb);
    chk("R6 timeout length", nb, TMO);
    chk_resp("R6 ignored", 32'd0, 32'd0);
    wr(3'd2, 32'hE);

    // R6 delay past the timeout
    rsp_mode = 2'd0; rsp_delay = 8'd200;
    issue(32'h0012_0000, 32'h0000_0100, nb);
    chk("R6 long delay timeout length", nb, TMO);
    chk_resp("R6 long delay ignored", 32'd0, 32'd0);
    wr(3'd2, 32'hE);

    // R7 ping with device map
    rsp_delay = 8'd2; dev_map = 12'hA5C;
    issue(32'd0, 32'd0, nb);
    chk_resp("R7 ping map", 32'h0000_00A5, 32'h0C00_0001);
    wr(3'd2, 32'hE);

    // R10 writes while busy
    rsp_delay = 8'd12;
    wr(3'd0, 32'h0012_3400);
    wr(3'd1, 32'h0000_5600);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R10 upper unchanged", v, 32'h0012_3400);
    rd(3'd1, v); chk("R10 lower unchanged", v, 32'h0000_5600);
    rd(3'd2, v); chk("R10 overrun while busy", v, 32'h5);
    repeat (15) @(negedge clk);
    rd(3'd2, v); chk("R10 overrun sticky", v, 32'h6);
    wr(3'd2, 32'h4);
    rd(3'd2, v); chk("R9 overrun clear keeps valid", v, 32'h2);

    // R11 launch over a stale response
    rsp_delay = 8'd1;
    wr(3'd1, 32'h0000_5700);
    rd(3'd2, v); chk("R11 stale set valid cleared", v, 32'h9);
    repeat (3) @(negedge clk);
    rd(3'd2, v); chk("R11 stale sticky after completion", v, 32'hA);
    wr(3'd2, 32'h8);
    rd(3'd2, v); chk("R9 stale clear", v, 32'h2);
    wr(3'd2, 32'h2);
    rd(3'd2, v); chk("R9 all clear", v, 32'h0);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule